// File: doc/BRIEF.md
# Power Mode Controller

This block turns a set of asynchronous board-level control pins and a handful of software control bits into clean, registered enables for the four functional domains of a transmitter front end: the I/Q modulator, the frequency synthesizer, the LO output buffer and the serial control interface. Each domain needs its own hardware pin and its own software bit to agree before it turns on. A hard shutdown pin and a software power-down bit sit above all of these and override them.

The block also decodes a 6-bit test code into charge-pump force controls and a select for the lock-status output multiplexer. It reports a 3-bit operating mode for the rest of the chip. The pins pass through two-flop synchronizers. The software bits come from a register file in the local clock domain and are used directly. Every output is registered.

Top module: `pmc_power_ctrl`

## Requirements
- R1: `mod_en_o` is 1 only when the block is active, `pin_tx_i` is 1 and `sw_tx_i` is 1. If either of the two is 0, `mod_en_o` is 0.
- R2: `lob_en_o` is 1 only when the block is active, `pin_lob_i` is 1 and `sw_lob_i` is 1. If either of the two is 0, `lob_en_o` is 0.
- R3: While `pin_run_ni` is 0, every enable is 0, including `serif_en_o`. Both force outputs are 0 and `mode_o` is 4 (hard off), whatever the other inputs are. This includes the software power-down bit.
- R4: While `pin_run_ni` is 1 and `sw_pwr_i` is 0, `serif_en_o` is 1. All other enables, both force outputs and `lock_sel_o` are 0, and `mode_o` is 5 (soft off).
- R5: When `pin_syn_i` is 0 on an active block, `synth_en_o` is 0 while the modulator follows R1. With the modulator on, `mode_o` is 1 (modulate only, external loop).
- R6: On an active block (run pin 1, `sw_pwr_i` 1), `mode_o` takes these values:
  - 0 (full transmit) when both the modulator and the synthesizer are on.
  - 2 (synthesize only) when `pin_tx_i` is 0 and the synthesizer is on.
  - 3 (soft mute) when `pin_tx_i` is 1, `sw_tx_i` is 0 and the synthesizer is on.
  - 6 (idle) when both the modulator and the synthesizer are off.
- R7: These settings apply only while `synth_en_o` is 1; otherwise both force outputs are 0.
  - Test code 6'b000001 sets `cp_src_o`.
  - Test code 6'b000010 sets `cp_snk_o`.
- R8: While `synth_en_o` is 1, `lock_sel_o` follows the test code; in all other cases it is 0 (lock detect).
  - Test code 6'b010000 gives 1 (reference divider output).
  - Test code 6'b011000 gives 2 (main divider output).
- R9: Test code 6'b000000 and every undefined code give normal operation: both force outputs 0 and `lock_sel_o` 0.
- R10: A change on a software bit or on the test code reaches the outputs after one clock edge. A change on a pin reaches the outputs after three edges: two synchronizer stages and the output register.
- R11: While `rst_ni` is 0, all enables and force outputs are 0, `lock_sel_o` is 0 and `mode_o` is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_run_ni | input | 1 | Hard shutdown pin, low shuts everything down (asynchronous) |
| pin_tx_i | input | 1 | Modulator enable pin (asynchronous) |
| pin_syn_i | input | 1 | Synthesizer enable pin (asynchronous) |
| pin_lob_i | input | 1 | LO buffer enable pin (asynchronous) |
| sw_pwr_i | input | 1 | Software power bit, 0 requests soft shutdown |
| sw_tx_i | input | 1 | Software modulator enable bit |
| sw_lob_i | input | 1 | Software LO buffer enable bit |
| test_code_i | input | 6 | Test code |
| mod_en_o | output | 1 | Modulator enable |
| synth_en_o | output | 1 | Synthesizer enable |
| lob_en_o | output | 1 | LO buffer enable |
| serif_en_o | output | 1 | Serial interface enable |
| cp_src_o | output | 1 | Force charge pump to source |
| cp_snk_o | output | 1 | Force charge pump to sink |
| lock_sel_o | output | 2 | Lock pin source: 0 detect, 1 reference divider, 2 main divider |
| mode_o | output | 3 | Decoded operating mode |

## Verification
Two shutdown functions can meet in one cycle. The bench drops the hard shutdown pin and clears the software power bit on the same edge. Because the two paths have different latencies, `mode_o` must first report soft off one edge later and then hard off two edges after that. The serial enable must stay on until the pin takes effect. A second collision comes from the synthesizer pin: the bench drops it while a charge-pump force code is held. The force must fall together with `synth_en_o`, and the modulator must stay on.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int TEST_W = 6;

  typedef enum logic [2:0] {
    MODE_TX     = 3'd0,
    MODE_MOD    = 3'd1,
    MODE_SYNTH  = 3'd2,
    MODE_MUTE   = 3'd3,
    MODE_HW_OFF = 3'd4,
    MODE_SW_OFF = 3'd5,
    MODE_IDLE   = 3'd6
  } pmc_mode_e;

  typedef enum logic [1:0] {
    LK_DETECT   = 2'd0,
    LK_REF_DIV  = 2'd1,
    LK_MAIN_DIV = 2'd2
  } lock_sel_e;

  localparam logic [TEST_W-1:0] TC_CP_SRC  = 6'b000001;
  localparam logic [TEST_W-1:0] TC_CP_SNK  = 6'b000010;
  localparam logic [TEST_W-1:0] TC_LK_REF  = 6'b010000;
  localparam logic [TEST_W-1:0] TC_LK_MAIN = 6'b011000;

  typedef struct packed {
    logic mod_en;
    logic synth_en;
    logic lob_en;
    logic serif_en;
  } pmc_en_t;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pmc_mode_logic.sv
module pmc_mode_logic
  import pmc_pkg::*;
(
  input  logic      run_i,
  input  logic      tx_pin_i,
  input  logic      syn_pin_i,
  input  logic      lob_pin_i,
  input  logic      pwr_bit_i,
  input  logic      tx_bit_i,
  input  logic      lob_bit_i,
  output pmc_en_t   en_o,
  output pmc_mode_e mode_o
);
  logic active, tx_on;

  assign active = run_i & pwr_bit_i;
  assign tx_on  = tx_pin_i & tx_bit_i;

  always_comb begin
    en_o.serif_en = run_i;
    en_o.mod_en   = active & tx_on;
    en_o.synth_en = active & syn_pin_i;
    en_o.lob_en   = active & lob_pin_i & lob_bit_i;
  end

  // hard off beats soft off beats everything else
  always_comb begin
    if (!run_i)                    mode_o = MODE_HW_OFF;
    else if (!pwr_bit_i)           mode_o = MODE_SW_OFF;
    else if (tx_on && syn_pin_i)   mode_o = MODE_TX;
    else if (tx_on)                mode_o = MODE_MOD;
    else if (syn_pin_i && tx_pin_i) mode_o = MODE_MUTE;
    else if (syn_pin_i)            mode_o = MODE_SYNTH;
    else                           mode_o = MODE_IDLE;
  end
endmodule

// File: rtl/pmc_test_decode.sv
module pmc_test_decode
  import pmc_pkg::*;
(
  input  logic [TEST_W-1:0] code_i,
  input  logic              synth_on_i,
  output logic              cp_src_o,
  output logic              cp_snk_o,
  output lock_sel_e         lock_sel_o
);
  always_comb begin
    cp_src_o   = 1'b0;
    cp_snk_o   = 1'b0;
    lock_sel_o = LK_DETECT;
    if (synth_on_i) begin
      case (code_i)
        TC_CP_SRC:  cp_src_o   = 1'b1;
        TC_CP_SNK:  cp_snk_o   = 1'b1;
        TC_LK_REF:  lock_sel_o = LK_REF_DIV;
        TC_LK_MAIN: lock_sel_o = LK_MAIN_DIV;
        default:    ; // undefined codes run as normal
      endcase
    end
  end
endmodule

// File: rtl/pmc_power_ctrl.sv
module pmc_power_ctrl
  import pmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_run_ni,
  input  logic              pin_tx_i,
  input  logic              pin_syn_i,
  input  logic              pin_lob_i,
  input  logic              sw_pwr_i,
  input  logic              sw_tx_i,
  input  logic              sw_lob_i,
  input  logic [TEST_W-1:0] test_code_i,
  output logic              mod_en_o,
  output logic              synth_en_o,
  output logic              lob_en_o,
  output logic              serif_en_o,
  output logic              cp_src_o,
  output logic              cp_snk_o,
  output logic [1:0]        lock_sel_o,
  output logic [2:0]        mode_o
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] pins_raw, pins_s;
  pmc_en_t          en_d;
  pmc_mode_e        mode_d;
  logic             src_d, snk_d;
  lock_sel_e        sel_d;

  assign pins_raw = {pin_run_ni, pin_tx_i, pin_syn_i, pin_lob_i};

  pmc_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  pmc_mode_logic u_mode (
    .run_i     (pins_s[3]),
    .tx_pin_i  (pins_s[2]),
    .syn_pin_i (pins_s[1]),
    .lob_pin_i (pins_s[0]),
    .pwr_bit_i (sw_pwr_i),
    .tx_bit_i  (sw_tx_i),
    .lob_bit_i (sw_lob_i),
    .en_o      (en_d),
    .mode_o    (mode_d)
  );

  pmc_test_decode u_test (
    .code_i     (test_code_i),
    .synth_on_i (en_d.synth_en),
    .cp_src_o   (src_d),
    .cp_snk_o   (snk_d),
    .lock_sel_o (sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_en_o   <= 1'b0;
      synth_en_o <= 1'b0;
      lob_en_o   <= 1'b0;
      serif_en_o <= 1'b0;
      cp_src_o   <= 1'b0;
      cp_snk_o   <= 1'b0;
      lock_sel_o <= LK_DETECT;
      mode_o     <= MODE_HW_OFF;
    end else begin
      mod_en_o   <= en_d.mod_en;
      synth_en_o <= en_d.synth_en;
      lob_en_o   <= en_d.lob_en;
      serif_en_o <= en_d.serif_en;
      cp_src_o   <= src_d;
      cp_snk_o   <= snk_d;
      lock_sel_o <= sel_d;
      mode_o     <= mode_d;
    end
  end
endmodule

// File: rtl/pmc_power_ctrl_chk.sv
module pmc_power_ctrl_chk
  import pmc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_pwr_i,
  input logic       sw_tx_i,
  input logic       sw_lob_i,
  input logic       mod_en_o,
  input logic       synth_en_o,
  input logic       lob_en_o,
  input logic       serif_en_o,
  input logic       cp_src_o,
  input logic       cp_snk_o,
  input logic [1:0] lock_sel_o,
  input logic [2:0] mode_o
);
  a_r1_mod_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_o |-> $past(sw_tx_i));

  a_r2_lob_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lob_en_o |-> $past(sw_lob_i));

  a_r3_hw_off_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_HW_OFF) |-> !(serif_en_o || mod_en_o || synth_en_o || lob_en_o || cp_src_o || cp_snk_o));

  a_r3_serial_only_in_hw_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serif_en_o |-> (mode_o == MODE_HW_OFF));

  a_r4_sw_off_serial_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SW_OFF) |-> (serif_en_o && !mod_en_o && !synth_en_o && !lob_en_o && lock_sel_o == 2'd0));

  a_r4_pwr_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sw_pwr_i) |-> !(mod_en_o || synth_en_o || lob_en_o));

  a_r5_mod_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_MOD) |-> (mod_en_o && !synth_en_o));

  a_r7_cp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cp_src_o && cp_snk_o));

  a_r7_cp_needs_synth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_src_o || cp_snk_o) |-> synth_en_o);

  a_r8_lock_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_sel_o != 2'd3) && ((lock_sel_o != 2'd0) -> synth_en_o));
endmodule

bind pmc_power_ctrl pmc_power_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_pwr_i   (sw_pwr_i),
  .sw_tx_i    (sw_tx_i),
  .sw_lob_i   (sw_lob_i),
  .mod_en_o   (mod_en_o),
  .synth_en_o (synth_en_o),
  .lob_en_o   (lob_en_o),
  .serif_en_o (serif_en_o),
  .cp_src_o   (cp_src_o),
  .cp_snk_o   (cp_snk_o),
  .lock_sel_o (lock_sel_o),
  .mode_o     (mode_o)
);

// File: tb/pmc_power_ctrl_test.sv
module pmc_power_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_run_ni = 1'b1, pin_tx_i = 1'b1, pin_syn_i = 1'b1, pin_lob_i = 1'b1;
  logic       sw_pwr_i = 1'b1, sw_tx_i = 1'b1, sw_lob_i = 1'b1;
  logic [5:0] test_code_i = 6'b0;
  logic       mod_en_o, synth_en_o, lob_en_o, serif_en_o, cp_src_o, cp_snk_o;
  logic [1:0] lock_sel_o;
  logic [2:0] mode_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pmc_power_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pin_run_ni(pin_run_ni), .pin_tx_i(pin_tx_i), .pin_syn_i(pin_syn_i), .pin_lob_i(pin_lob_i),
    .sw_pwr_i(sw_pwr_i), .sw_tx_i(sw_tx_i), .sw_lob_i(sw_lob_i), .test_code_i(test_code_i),
    .mod_en_o(mod_en_o), .synth_en_o(synth_en_o), .lob_en_o(lob_en_o), .serif_en_o(serif_en_o),
    .cp_src_o(cp_src_o), .cp_snk_o(cp_snk_o), .lock_sel_o(lock_sel_o), .mode_o(mode_o)
  );

  // {run,tx,syn,lob pins}{pwr,tx,lob bits}{code}{mod,syn,lob,ser}{src,snk}{sel}{mode}
  localparam logic [23:0] VEC [16] = '{
    {4'b1111, 3'b111, 6'b000000, 4'b1111, 2'b00, 2'd0, 3'd0},
    {4'b1111, 3'b110, 6'b000000, 4'b1101, 2'b00, 2'd0, 3'd0},
    {4'b1011, 3'b111, 6'b000000, 4'b0111, 2'b00, 2'd0, 3'd2},
    {4'b1111, 3'b101, 6'b000000, 4'b0111, 2'b00, 2'd0, 3'd3},
    {4'b1101, 3'b111, 6'b000000, 4'b1011, 2'b00, 2'd0, 3'd1},
    {4'b1000, 3'b111, 6'b000000, 4'b0001, 2'b00, 2'd0, 3'd6},
    {4'b0111, 3'b111, 6'b000001, 4'b0000, 2'b00, 2'd0, 3'd4},
    {4'b1111, 3'b011, 6'b010000, 4'b0001, 2'b00, 2'd0, 3'd5},
    {4'b1111, 3'b111, 6'b000001, 4'b1111, 2'b10, 2'd0, 3'd0},
    {4'b1111, 3'b111, 6'b000010, 4'b1111, 2'b01, 2'd0, 3'd0},
    {4'b1111, 3'b111, 6'b010000, 4'b1111, 2'b00, 2'd1, 3'd0},
    {4'b1111, 3'b111, 6'b011000, 4'b1111, 2'b00, 2'd2, 3'd0},
    {4'b1111, 3'b111, 6'b000011, 4'b1111, 2'b00, 2'd0, 3'd0},
    {4'b1111, 3'b111, 6'b111111, 4'b1111, 2'b00, 2'd0, 3'd0},
    {4'b1101, 3'b111, 6'b000001, 4'b1011, 2'b00, 2'd0, 3'd1},
    {4'b0111, 3'b011, 6'b000010, 4'b0000, 2'b00, 2'd0, 3'd4}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 R2 R6 full transmit";
      1: return "R2 buffer bit off";
      2: return "R6 synth only";
      3: return "R1 R6 soft mute";
      4: return "R5 external loop";
      5: return "R6 idle";
      6: return "R3 hard off";
      7: return "R4 soft off";
      8, 9: return "R7 charge pump force";
      10, 11: return "R8 lock select";
      12, 13: return "R9 undefined code";
      14: return "R7 force gated by synth";
      default: return "R3 hard over soft";
    endcase
  endfunction

  function automatic logic [10:0] observed();
    return {mod_en_o, synth_en_o, lob_en_o, serif_en_o, cp_src_o, cp_snk_o, lock_sel_o, mode_o};
  endfunction

  task automatic chk(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [12:0] s);
    {pin_run_ni, pin_tx_i, pin_syn_i, pin_lob_i, sw_pwr_i, sw_tx_i, sw_lob_i, test_code_i} = s;
  endtask

  initial begin
    // R11 reset state, inputs all high
    repeat (3) @(negedge clk);
    chk("R11 reset", observed(), {4'b0000, 2'b00, 2'd0, 3'd4});
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      apply(VEC[i][23:11]);
      repeat (4) @(negedge clk);
      chk(vec_tag(i), observed(), VEC[i][10:0]);
    end

    // R10 software latency: one edge
    apply({4'b1111, 3'b111, 6'b000000});
    repeat (4) @(negedge clk);
    sw_tx_i = 1'b0;
    @(negedge clk);
    chk("R10 bit latency", {10'b0, mod_en_o}, 11'd0);
    sw_tx_i = 1'b1;
    repeat (2) @(negedge clk);

    // R10 pin latency: three edges
    pin_tx_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 pin still old", {10'b0, mod_en_o}, 11'd1);
    @(negedge clk);
    chk("R10 pin taken", {10'b0, mod_en_o}, 11'd0);
    pin_tx_i = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 same-cycle hard and soft shutdown
    pin_run_ni = 1'b0;
    sw_pwr_i   = 1'b0;
    @(negedge clk);
    chk("R4 soft off first", observed(), {4'b0001, 2'b00, 2'd0, 3'd5});
    repeat (2) @(negedge clk);
    chk("R3 hard off wins", observed(), {4'b0000, 2'b00, 2'd0, 3'd4});
    apply({4'b1111, 3'b111, 6'b000001});
    repeat (4) @(negedge clk);
    chk("R7 source on", observed(), {4'b1111, 2'b10, 2'd0, 3'd0});

    // R5 R7 synth pin drops while force held
    pin_syn_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 R7 synth drop", observed(), {4'b1011, 2'b00, 2'd0, 3'd1});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule